// File: doc/BRIEF.md
# Mode-Gated Periodic Down-Counter with Interrupt

This block is one periodic 16-bit down-counter with its own small register interface and one interrupt request line. Software sets a modulus, a power-of-two prescale exponent and a few control bits. The counter then steps down once per prescaled tick. When a tick arrives while the count is zero, the block raises a sticky flag and starts the next period, either from the modulus or from 0xFFFF.

Four system mode inputs decide whether the counter may advance. Wait mode never stops it. Stop mode always freezes it. Doze mode and debug mode freeze it only when the matching control bit is set. A freeze holds the count, the prescaler phase and the flag exactly as they were, and counting picks up from that state once the freeze ends. Register writes still take effect during a freeze.

The bus accepts byte and halfword accesses from supervisor mode only. Any other access gets an error response: a wide access, a reserved size, or a user-mode access. An access with an error response leaves the registers unchanged and reads back zero.

Top module: `mgt_top`

## Requirements
- R1: After reset the block is in this state: control reads 0x0000, modulus reads 0xFFFF, count reads 0xFFFF, irq is low.
- R2: Register addresses are fixed: offset 0 holds control, offset 2 holds the modulus, offset 4 holds the count (read-only), and offset 6 reads 0. `bus_size` takes 0 for a byte, 1 for a halfword, 2 for a word and 3 reserved. A halfword access ignores `bus_addr[0]`. A byte access with `bus_addr[0]`=1 writes bits 15:8 from `bus_wdata[15:8]`; with `bus_addr[0]`=0 it writes bits 7:0 from `bus_wdata[7:0]`. A read returns the whole halfword. Sizes 2 and 3 assert `bus_err` in the same cycle, change no register and read 0.
- R3: Any request with `bus_sup`=0 asserts `bus_err`, reads 0 and changes no register.
- R4: Control bit 0 is enable. Setting it loads the counter from the modulus. Clearing it resets the prescaler and holds the count.
- R5: Control bits 11:8 hold the exponent n. While the counter runs, it decrements once every 2^n running cycles.
- R6: A tick that finds the count at zero sets the flag (control bit 2). The count is then reloaded from the modulus if control bit 1 is set, or wraps to 0xFFFF if it is clear.
- R7: Writing 1 to control bit 2 clears the flag. A hardware set in the same cycle wins over the clear. irq is the flag ANDed with control bit 3.
- R8: With control bit 4 set, a modulus write also loads the counter with the new value at the same edge.
- R9: With `mode_doze` high and control bit 6 set, the counter and prescaler freeze. With control bit 6 clear, doze has no effect. `mode_wait` never affects counting.
- R10: With `mode_debug` high and control bit 5 set, the counter and prescaler freeze. Register writes made during this freeze take effect and remain after the freeze ends.
- R11: `mode_stop` high always freezes the counter. After any freeze, counting resumes from the held count and prescaler phase without a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Byte offset |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_sup | input | 1 | Supervisor privilege |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle |
| bus_err | output | 1 | Error response, same cycle |
| mode_wait | input | 1 | System in wait mode |
| mode_doze | input | 1 | System in doze mode |
| mode_stop | input | 1 | System in stop mode |
| mode_debug | input | 1 | System in debug mode |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count or a wrong prescaler phase becomes visible on the next count read. It then shifts the rise of irq by the same number of ticks, and that happens within one period of the running counter. A freeze that leaks shows up as a count that drifts across reads taken while the freeze is held. A freeze that loses state shows up as a count after release that differs from the count before entry. A missed error check shows up at once as a wrong bus_err or nonzero read data. It can also show up later, as a modulus or control value that an error access should have left unchanged.

// File: rtl/mgt_pkg.sv
package mgt_pkg;
  localparam int DW    = 16;
  localparam int EXP_W = 4;
  localparam int PS_W  = (1 << EXP_W) - 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSV  = 2'd3
  } bus_size_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MOD  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int B_EN   = 0;
  localparam int B_RLD  = 1;
  localparam int B_FLAG = 2;
  localparam int B_IE   = 3;
  localparam int B_OVW  = 4;
  localparam int B_DBG  = 5;
  localparam int B_DOZE = 6;
  localparam int B_EXP  = 8;

  localparam logic [DW-1:0] CTRL_WMASK = 16'h0F7B;
endpackage

// File: rtl/mgt_regs.sv
module mgt_regs
  import mgt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [1:0]    size,
  input  logic          sup,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cnt_i,
  input  logic          zero_evt_i,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic [DW-1:0] ctrl_o,
  output logic          flag_o,
  output logic [DW-1:0] mod_o,
  output logic          load_o,
  output logic [DW-1:0] load_val_o
);
  logic [DW-1:0] ctrl_q, ctrl_d, mod_q, mod_d;
  logic          flag_q, flag_d;
  logic          wr_ok, ctrl_we, mod_we, flag_clr;
  logic [1:0]    lanes;
  reg_sel_e      sel;

  function automatic logic [DW-1:0] merge_f(input logic [DW-1:0] old,
                                            input logic [DW-1:0] wd,
                                            input logic [1:0]    ln);
    merge_f = {ln[1] ? wd[15:8] : old[15:8], ln[0] ? wd[7:0] : old[7:0]};
  endfunction

  always_comb begin
    err      = req && (size == SZ_WORD || size == SZ_RSV || !sup);
    sel      = reg_sel_e'(addr[2:1]);
    lanes    = (size == SZ_HALF) ? 2'b11 : (addr[0] ? 2'b10 : 2'b01);
    wr_ok    = req && wr && !err;
    ctrl_we  = wr_ok && (sel == SEL_CTRL);
    mod_we   = wr_ok && (sel == SEL_MOD);
    ctrl_d   = merge_f(ctrl_q, wdata, lanes) & CTRL_WMASK;
    mod_d    = merge_f(mod_q, wdata, lanes);
    flag_clr = ctrl_we && lanes[0] && wdata[B_FLAG];
    flag_d   = zero_evt_i ? 1'b1 : (flag_clr ? 1'b0 : flag_q);
    load_o     = (ctrl_we && !ctrl_q[B_EN] && ctrl_d[B_EN]) ||
                 (mod_we && ctrl_q[B_OVW]);
    load_val_o = mod_we ? mod_d : mod_q;
    rdata = '0;
    if (req && !wr && !err) begin
      unique case (sel)
        SEL_CTRL: rdata = ctrl_q | (DW'(flag_q) << B_FLAG);
        SEL_MOD:  rdata = mod_q;
        SEL_CNT:  rdata = cnt_i;
        default:  rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mod_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (mod_we)  mod_q  <= mod_d;
      flag_q <= flag_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign flag_o = flag_q;
  assign mod_o  = mod_q;

  p_err_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr && err) |=> $stable(mod_q));
  p_user_rd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !sup) |-> (rdata == '0 && err));
  p_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(zero_evt_i));
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !zero_evt_i) |=> !flag_q);
endmodule

// File: rtl/mgt_prescale.sv
module mgt_prescale #(
  parameter int EXP_W = mgt_pkg::EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int PS_W = (1 << EXP_W) - 1;

  logic [PS_W-1:0] pcnt_q, pcnt_d, mask;
  logic            pcnt_en;

  always_comb begin
    mask    = ~({PS_W{1'b1}} << exp_i);
    tick_o  = run_i && ((pcnt_q & mask) == mask);
    pcnt_en = clr_i || run_i;
    if (clr_i || tick_o) pcnt_d = '0;
    else                 pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  p_frozen_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(pcnt_q));
endmodule

// File: rtl/mgt_counter.sv
module mgt_counter #(
  parameter int W = mgt_pkg::DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         reload_en_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_evt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    zero_evt_o = tick_i && (cnt_q == '0);
    cnt_en     = load_i || tick_i;
    if (load_i)          cnt_d = load_val_i;
    else if (zero_evt_o) cnt_d = reload_en_i ? mod_i : '1;
    else                 cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '1;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt_o && !load_i && reload_en_i) |=> (cnt_q == $past(mod_i)));
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mgt_top.sv
module mgt_top
  import mgt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [1:0]    bus_size,
  input  logic          bus_sup,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  input  logic          mode_wait,
  input  logic          mode_doze,
  input  logic          mode_stop,
  input  logic          mode_debug,
  output logic          irq
);
  logic          rst_meta, rst_sync_n;
  logic [DW-1:0] ctrl, modv, cnt, load_val;
  logic          flag, load, zero_evt, tick, run, frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    frozen = mode_stop || (mode_doze && ctrl[B_DOZE]) || (mode_debug && ctrl[B_DBG]);
    run    = ctrl[B_EN] && !frozen;
    irq    = flag && ctrl[B_IE];
  end

  mgt_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .req(bus_req), .wr(bus_wr), .addr(bus_addr),
    .size(bus_size), .sup(bus_sup), .wdata(bus_wdata), .cnt_i(cnt),
    .zero_evt_i(zero_evt), .rdata(bus_rdata), .err(bus_err), .ctrl_o(ctrl),
    .flag_o(flag), .mod_o(modv), .load_o(load), .load_val_o(load_val)
  );

  mgt_prescale #(.EXP_W(EXP_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(!ctrl[B_EN]), .run_i(run),
    .exp_i(ctrl[B_EXP +: EXP_W]), .tick_o(tick)
  );

  mgt_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .tick_i(tick), .load_i(load),
    .load_val_i(load_val), .reload_en_i(ctrl[B_RLD]), .mod_i(modv),
    .cnt_o(cnt), .zero_evt_o(zero_evt)
  );

  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frozen && !load) |=> $stable(cnt));
  p_wait_free_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_wait && ctrl[B_EN] && !mode_stop && !mode_doze && !mode_debug) |-> run);
  p_debug_gate_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_debug && ctrl[B_DBG]) |-> !tick);
endmodule

// File: tb/mgt_top_tb.sv
module mgt_top_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_wr, bus_sup;
  logic [2:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_err, irq;
  logic        mode_wait, mode_doze, mode_stop, mode_debug;

  int    n_vec = 0;
  int    n_fail = 0;
  string cur = "R1";

  logic [15:0] m_ctrl, m_mod, m_cnt;
  logic [14:0] m_pcnt;
  logic        m_flag;

  always #5 clk = ~clk;

  mgt_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_sup(bus_sup),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .mode_wait(mode_wait), .mode_doze(mode_doze), .mode_stop(mode_stop),
    .mode_debug(mode_debug), .irq(irq)
  );

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", cur, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lane_merge(input logic [15:0] old, input logic [15:0] wd,
                                             input logic [1:0] sz, input logic a0);
    logic [15:0] r;
    r = old;
    if (sz == 2'd1) r = wd;
    else if (a0)    r[15:8] = wd[15:8];
    else            r[7:0]  = wd[7:0];
    return r;
  endfunction

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    case (a[2:1])
      2'd0:    return m_ctrl | {13'd0, m_flag, 2'd0};
      2'd1:    return m_mod;
      2'd2:    return m_cnt;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic cyc(input logic rq, input logic w, input logic [2:0] a,
                     input logic [1:0] sz, input logic sp, input logic [15:0] wd);
    logic        e_err, run, tick, zero, c_we, m_we;
    logic [14:0] mask, n_pcnt;
    logic [15:0] n_ctrl, n_mod, n_cnt;
    logic        n_flag;
    bus_req = rq; bus_wr = w; bus_addr = a; bus_size = sz; bus_sup = sp; bus_wdata = wd;
    #1;
    e_err = rq && (sz >= 2'd2 || !sp);
    if (rq) chk("err", {15'd0, bus_err}, {15'd0, e_err});
    if (rq && !w) chk("rdata", bus_rdata, e_err ? 16'h0000 : exp_read(a));
    run    = m_ctrl[0] && !mode_stop && !(mode_debug && m_ctrl[5]) && !(mode_doze && m_ctrl[6]);
    mask   = (15'd1 << m_ctrl[11:8]) - 15'd1;
    tick   = run && ((m_pcnt & mask) == mask);
    n_pcnt = !m_ctrl[0] ? 15'd0 : (tick ? 15'd0 : (run ? m_pcnt + 15'd1 : m_pcnt));
    zero   = tick && (m_cnt == 16'd0);
    n_cnt  = tick ? ((m_cnt == 16'd0) ? (m_ctrl[1] ? m_mod : 16'hFFFF) : m_cnt - 16'd1) : m_cnt;
    c_we   = rq && w && !e_err && a[2:1] == 2'd0;
    m_we   = rq && w && !e_err && a[2:1] == 2'd1;
    n_ctrl = c_we ? (lane_merge(m_ctrl, wd, sz, a[0]) & 16'h0F7B) : m_ctrl;
    n_mod  = m_we ? lane_merge(m_mod, wd, sz, a[0]) : m_mod;
    n_flag = m_flag;
    if (c_we && (sz == 2'd1 || !a[0]) && wd[2]) n_flag = 1'b0;
    if (zero) n_flag = 1'b1;
    if (c_we && n_ctrl[0] && !m_ctrl[0]) n_cnt = n_mod;
    if (m_we && m_ctrl[4]) n_cnt = n_mod;
    @(posedge clk);
    @(negedge clk);
    m_ctrl = n_ctrl; m_mod = n_mod; m_cnt = n_cnt; m_pcnt = n_pcnt; m_flag = n_flag;
    bus_req = 1'b0; bus_wr = 1'b0;
    chk("irq", {15'd0, irq}, {15'd0, m_flag && m_ctrl[3]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 2'd1, 1'b1, 16'h0);
  endtask
  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    cyc(1'b1, 1'b1, a, 2'd1, 1'b1, d);
  endtask
  task automatic rd(input logic [2:0] a, input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, a, 2'd1, 1'b1, 16'h0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [2:0]  a;
    logic [1:0]  sz;
    logic [15:0] wd;
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_req = 0; bus_wr = 0; bus_addr = 0; bus_size = 1; bus_sup = 1;
    bus_wdata = 0; mode_wait = 0; mode_doze = 0; mode_stop = 0; mode_debug = 0;
    m_ctrl = 16'h0; m_mod = 16'hFFFF; m_cnt = 16'hFFFF; m_pcnt = 15'd0; m_flag = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cur = "R1"; idle(3); rd(3'd0, 1); rd(3'd2, 1); rd(3'd4, 1); rd(3'd6, 1);

    cur = "R2";
    cyc(1, 1, 3'd2, 2'd2, 1, 16'h0005); cyc(1, 1, 3'd2, 2'd3, 1, 16'h0005);
    cyc(1, 0, 3'd2, 2'd2, 1, 16'h0); rd(3'd2, 1);
    cyc(1, 1, 3'd2, 2'd0, 1, 16'hAA05); rd(3'd2, 1);
    cyc(1, 1, 3'd3, 2'd0, 1, 16'h0077); rd(3'd2, 1);
    cyc(1, 0, 3'd3, 2'd0, 1, 16'h0);

    cur = "R3";
    cyc(1, 1, 3'd0, 2'd1, 0, 16'h000B); cyc(1, 1, 3'd2, 2'd0, 0, 16'h00FF);
    cyc(1, 0, 3'd4, 2'd1, 0, 16'h0); rd(3'd0, 1); rd(3'd2, 1);

    cur = "R4"; wr16(3'd0, 16'h000B); rd(3'd4, 10);
    wr16(3'd0, 16'h000A); idle(3); rd(3'd4, 2);
    wr16(3'd0, 16'h000B); rd(3'd4, 3);

    cur = "R7"; rd(3'd0, 4); cyc(1, 1, 3'd0, 2'd0, 1, 16'h000F); rd(3'd0, 2);
    wr16(3'd0, 16'h0003); rd(3'd4, 10); rd(3'd0, 1); wr16(3'd0, 16'h000F); rd(3'd0, 1);

    cur = "R5"; wr16(3'd0, 16'h020B); rd(3'd4, 24);
    wr16(3'd0, 16'h010B); rd(3'd4, 12);

    cur = "R6"; wr16(3'd2, 16'h0002); wr16(3'd0, 16'h0009); rd(3'd4, 12);

    cur = "R8"; wr16(3'd0, 16'h0019); wr16(3'd2, 16'h0004); rd(3'd4, 4);

    cur = "R9"; wr16(3'd0, 16'h0043); mode_doze = 1; rd(3'd4, 6);
    wr16(3'd0, 16'h0003); rd(3'd4, 4); mode_doze = 0;
    mode_wait = 1; rd(3'd4, 5); mode_wait = 0;

    cur = "R10"; wr16(3'd0, 16'h0033); mode_debug = 1; rd(3'd4, 4);
    wr16(3'd2, 16'h0007); rd(3'd4, 3); rd(3'd2, 1);
    mode_debug = 0; rd(3'd4, 5); rd(3'd2, 1);

    cur = "R11"; wr16(3'd0, 16'h0103); rd(3'd4, 3);
    mode_stop = 1; rd(3'd4, 5); idle(2); mode_stop = 0; rd(3'd4, 6);

    cur = "R6";
    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0) begin
        mode_doze  = ($urandom % 4) == 0;
        mode_debug = ($urandom % 5) == 0;
        mode_stop  = ($urandom % 8) == 0;
        mode_wait  = $urandom % 2;
      end
      a  = 3'($urandom);
      sz = (($urandom % 8) == 0) ? 2'($urandom) : 2'($urandom % 2);
      wd = 16'($urandom);
      if (a[2:1] == 2'd0) wd = wd & 16'h017F;
      else                wd = wd & 16'h003F;
      cyc(($urandom % 4) != 0, ($urandom % 5) == 0, a, sz, ($urandom % 10) != 0, wd);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule